// File: doc/BRIEF.md
# External test vector bus master

This block lets an external tester drive transfers on an internal AHB-style bus through a few pins. The tester uses two request inputs, one acknowledge output and a shared 32-bit data bus. The data bus is modelled here as a separate input, an output and an output enable. Raising the first request input makes the block ask for the internal bus. Once the bus is granted, the block acknowledges and enters test mode.

In test mode, the request pair the tester applies in one cycle announces the kind of vector it will present on the data bus in the next cycle. One code covers address, control and turnaround vectors. The block tells them apart from the order of the cycles: a lone one carries an address, the last of a run placed just before a read or write carries transfer attributes, and the ones after a read are turnaround slots. Each read or write vector becomes one bus transfer. Back-to-back transfers of the same direction form a burst. A stall on the internal bus pulls acknowledge low, and the tester must hold its vector until acknowledge returns. The bus address is the latched address vector. A neighbouring incrementer, which is a separate block, receives the increment enable and applies any burst offsets.

Top module: `tvec_master`

## Requirements
- R1: In normal mode, a HIGH `req_a` makes `bus_req` go HIGH after the next clock edge. Once `bus_grant` is sampled HIGH, test mode begins and `ack` is HIGH from the following cycle.
- R2: In test mode, the pair {`req_a`,`req_b`} sampled in one cycle sets the type of the vector on `xd_in` in the next cycle. The codes are: 2'b11 address/control/turnaround, 2'b10 write, 2'b01 read, 2'b00 exit.
- R3: An address vector latches `xd_in` and drives it on `m_addr`. During an address vector, `m_trans` is IDLE (2'b00).
- R4: A write vector drives an address phase in its own cycle with `m_write`=1. The `xd_in` data of that cycle appears on `m_wdata` in the next cycle. The first transfer after any other vector is NONSEQ (2'b10). A transfer that directly follows one of the same direction is SEQ (2'b11).
- R5: A read vector drives an address phase with `m_write`=0 while `xd_oe` stays LOW. In the next cycle, `xd_oe` is HIGH and `xd_out` carries `m_rdata`.
- R6: A 2'b11 vector that directly follows an address vector, and is itself followed by a read or write request, is a control vector. Its data does not change `m_addr`.
- R7: A control vector with bit 0 HIGH loads the transfer attributes from these bits: bits 3:2 set size[1:0], bit 4 sets lock, bits 5, 6, 9 and 10 set protection bits 0 to 3, and bit 7 sets the increment enable. With bit 0 LOW, the attributes are unchanged.
- R8: After reset, `m_size`=3'b010, `m_prot`=4'b0011, `m_lock`=0 and `m_incr_en`=0. `m_size[2]` is always 0. After reset, `ack`, `bus_req`, `xd_oe` and `m_trans` are also 0.
- R9: After a read, the next TURN_N (default 2) 2'b11 vectors are turnaround slots and leave `m_addr` unchanged. `xd_oe` falls after the last read data phase.
- R10: After test mode is entered, read and write vectors issue no transfer (`m_trans` IDLE) until an address vector has been taken.
- R11: While a data phase sees `m_ready` LOW, `ack` is LOW, the address phase outputs hold, and the held vector is taken exactly once after `m_ready` returns.
- R12: `bus_req` stays HIGH for the whole of test mode. An exit vector (2'b00) makes `ack` and `bus_req` go LOW after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a | input | 1 | Tester request, high bit of the vector code |
| req_b | input | 1 | Tester request, low bit of the vector code |
| ack | output | 1 | Test mode active and not stalled |
| xd_in | input | DW | Data bus value driven by the tester |
| xd_out | output | DW | Read data driven towards the tester |
| xd_oe | output | 1 | Output enable for xd_out |
| bus_req | output | 1 | Internal bus request |
| bus_grant | input | 1 | Internal bus grant |
| m_trans | output | 2 | Transfer type: IDLE 00, NONSEQ 10, SEQ 11 |
| m_addr | output | AW | Transfer address |
| m_write | output | 1 | Write transfer |
| m_size | output | 3 | Transfer size |
| m_prot | output | 4 | Protection attributes |
| m_lock | output | 1 | Locked transfer |
| m_incr_en | output | 1 | Increment enable for the neighbouring address incrementer |
| m_wdata | output | DW | Write data in the data phase |
| m_rdata | input | DW | Read data from the internal bus |
| m_ready | input | 1 | Data phase complete |

## Verification
On every cycle, the assertions check four things. First, test mode only starts after a grant, and its first cycle issues no transfer. Second, a stall freezes the address phase. Third, a SEQ transfer always follows a non-IDLE cycle. Fourth, the data bus is only driven after a read address phase, and the transfer attributes never change without a valid control vector. The directed scenarios are the only proof that vector sequences are classified correctly. They cover an address against a control vector, turnaround slots that keep the address, and an ignored control vector. The scenarios also confirm the exact cycle in which write data, read data and the bus direction appear, that a stalled write is taken once, and that the exit sequence releases the bus.

// File: rtl/tvm_pkg.sv
package tvm_pkg;

  // Vector type carried on the data bus in the current cycle (R2)
  typedef enum logic [2:0] {
    VT_NONE, VT_ADDR, VT_WR, VT_RD, VT_EXIT
  } vtype_t;

  // Meaning of the current vector after sequence analysis
  typedef enum logic [2:0] {
    K_NONE, K_ADDR, K_CTRL, K_TURN, K_WR, K_RD, K_EXIT
  } vkind_t;

  typedef struct packed {
    logic [1:0] size;
    logic       lock;
    logic [3:0] prot;
    logic       incr;
  } xattr_t;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  function automatic vtype_t pair_to_type(input logic [1:0] pair);
    case (pair)
      2'b11:   return VT_ADDR;
      2'b10:   return VT_WR;
      2'b01:   return VT_RD;
      default: return VT_EXIT;
    endcase
  endfunction

endpackage

// File: rtl/tvm_classify.sv
module tvm_classify
  import tvm_pkg::*;
#(
  parameter int TURN_N = 2,
  localparam int CW = $clog2(TURN_N + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       adv,
  input  logic [1:0] pair,
  output vkind_t     kind
);

  vtype_t        vt_q, vt_d;
  logic          prev_addr_q, prev_addr_d;
  logic [CW-1:0] skip_q, skip_d;
  logic          next_is_xfer;

  assign next_is_xfer = (pair == 2'b10) || (pair == 2'b01);

  // R6, R9: shared code resolved from the surrounding cycles
  always_comb begin
    case (vt_q)
      VT_ADDR: begin
        if (skip_q != '0)                      kind = K_TURN;
        else if (prev_addr_q && next_is_xfer)  kind = K_CTRL;
        else                                   kind = K_ADDR;
      end
      VT_WR:   kind = K_WR;
      VT_RD:   kind = K_RD;
      VT_EXIT: kind = K_EXIT;
      default: kind = K_NONE;
    endcase
  end

  always_comb begin
    vt_d        = vt_q;
    prev_addr_d = prev_addr_q;
    skip_d      = skip_q;
    if (start) begin
      vt_d        = VT_NONE;
      prev_addr_d = 1'b0;
      skip_d      = '0;
    end else if (adv) begin
      vt_d        = pair_to_type(pair);   // R2: pipelined one cycle
      prev_addr_d = (kind == K_ADDR);
      case (kind)
        K_RD:    skip_d = CW'(TURN_N);
        K_TURN:  skip_d = skip_q - 1'b1;
        K_NONE:  skip_d = skip_q;
        default: skip_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vt_q        <= VT_NONE;
      prev_addr_q <= 1'b0;
      skip_q      <= '0;
    end else begin
      vt_q        <= vt_d;
      prev_addr_q <= prev_addr_d;
      skip_q      <= skip_d;
    end
  end

endmodule

// File: rtl/tvm_attr_reg.sv
module tvm_attr_reg
  import tvm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] cvec,
  output xattr_t        attr
);

  // R8: word size, privileged data access, no cache, no buffer
  localparam xattr_t ATTR_RST = '{size: 2'b10, lock: 1'b0, prot: 4'b0011, incr: 1'b0};

  xattr_t attr_q, attr_d;
  logic   take;
  logic   unused_cvec;

  assign unused_cvec = ^{cvec[1], cvec[8], cvec[DW-1:11]};
  assign take = load && cvec[0];

  // R7: field positions fixed by the tester's vector format
  always_comb begin
    attr_d = attr_q;
    if (take) begin
      attr_d.size = cvec[3:2];
      attr_d.lock = cvec[4];
      attr_d.prot = {cvec[10], cvec[9], cvec[6], cvec[5]};
      attr_d.incr = cvec[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attr_q <= ATTR_RST;
    else if (take) attr_q <= attr_d;
  end

  assign attr = attr_q;

  assert_attr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && cvec[0]) |=> $stable(attr_q));

endmodule

// File: rtl/tvm_dphase.sv
module tvm_dphase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic          issue,
  input  logic          issue_wr,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] rdata_in,
  input  logic          ready,
  output logic          stall,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_out,
  output logic          oe
);

  logic          act_q, act_d;
  logic          wr_q, wr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          wd_en;

  assign wd_en = adv && issue && issue_wr;

  always_comb begin
    act_d = act_q;
    wr_d  = wr_q;
    wd_d  = wd_q;
    if (start) begin
      act_d = 1'b0;
      wr_d  = 1'b0;
    end else if (adv) begin
      act_d = issue;
      wr_d  = issue_wr;
    end
    if (wd_en) wd_d = wdata_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      wd_q  <= '0;
    end else begin
      act_q <= act_d;
      wr_q  <= wr_d;
      if (wd_en) wd_q <= wd_d;
    end
  end

  assign stall     = act_q && !ready;      // R11
  assign oe        = act_q && !wr_q;       // R5, R9
  assign rdata_out = oe ? rdata_in : '0;
  assign wdata     = wd_q;                 // R4

  assert_oe_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> ($past(issue && !issue_wr) || $past(oe)));

endmodule

// File: rtl/tvec_master.sv
module tvec_master
  import tvm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int TURN_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_a,
  input  logic          req_b,
  output logic          ack,
  input  logic [DW-1:0] xd_in,
  output logic [DW-1:0] xd_out,
  output logic          xd_oe,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [1:0]    m_trans,
  output logic [AW-1:0] m_addr,
  output logic          m_write,
  output logic [2:0]    m_size,
  output logic [3:0]    m_prot,
  output logic          m_lock,
  output logic          m_incr_en,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_ready
);

  typedef enum logic [1:0] {S_NORM, S_WAIT, S_TEST} mode_t;

  mode_t         state_q, state_d;
  vkind_t        kind;
  xattr_t        attr;
  logic          stall, adv, start, in_test;
  logic          xfer_now, is_wr;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_ok_q, addr_ok_d;
  logic          prev_xfer_q, prev_xfer_d;
  logic          prev_wr_q, prev_wr_d;

  assign in_test = (state_q == S_TEST);
  assign adv     = in_test && !stall;
  assign start   = (state_q == S_WAIT) && bus_grant;

  // R1, R12: mode handshake
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_NORM: if (req_a) state_d = S_WAIT;
      S_WAIT: begin
        if (!req_a)         state_d = S_NORM;
        else if (bus_grant) state_d = S_TEST;
      end
      S_TEST: if (adv && kind == K_EXIT) state_d = S_NORM;
      default: state_d = S_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_NORM;
    else        state_q <= state_d;
  end

  tvm_classify #(.TURN_N(TURN_N)) i_classify (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .adv   (adv),
    .pair  ({req_a, req_b}),
    .kind  (kind)
  );

  tvm_attr_reg #(.DW(DW)) i_attr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (adv && kind == K_CTRL),
    .cvec  (xd_in),
    .attr  (attr)
  );

  // R10: transfers only once an address has been taken
  assign is_wr    = (kind == K_WR);
  assign xfer_now = in_test && addr_ok_q && (kind == K_WR || kind == K_RD);

  tvm_dphase #(.DW(DW)) i_dphase (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .adv       (adv),
    .issue     (xfer_now),
    .issue_wr  (is_wr),
    .wdata_in  (xd_in),
    .rdata_in  (m_rdata),
    .ready     (m_ready),
    .stall     (stall),
    .wdata     (m_wdata),
    .rdata_out (xd_out),
    .oe        (xd_oe)
  );

  always_comb begin
    addr_d      = addr_q;
    addr_ok_d   = addr_ok_q;
    prev_xfer_d = prev_xfer_q;
    prev_wr_d   = prev_wr_q;
    if (start) begin
      addr_ok_d   = 1'b0;
      prev_xfer_d = 1'b0;
    end else if (adv) begin
      if (kind == K_ADDR) begin           // R3
        addr_d    = xd_in[AW-1:0];
        addr_ok_d = 1'b1;
      end
      prev_xfer_d = xfer_now;
      prev_wr_d   = is_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      addr_ok_q   <= 1'b0;
      prev_xfer_q <= 1'b0;
      prev_wr_q   <= 1'b0;
    end else begin
      addr_q      <= addr_d;
      addr_ok_q   <= addr_ok_d;
      prev_xfer_q <= prev_xfer_d;
      prev_wr_q   <= prev_wr_d;
    end
  end

  // R4: burst continuation only within one direction
  assign m_trans   = !xfer_now ? TR_IDLE :
                     (prev_xfer_q && (prev_wr_q == is_wr)) ? TR_SEQ : TR_NONSEQ;
  assign m_write   = xfer_now && is_wr;
  assign m_addr    = addr_q;
  assign m_size    = {1'b0, attr.size};
  assign m_prot    = attr.prot;
  assign m_lock    = attr.lock;
  assign m_incr_en = attr.incr;

  assign ack     = in_test && !stall;      // R11
  assign bus_req = (state_q != S_NORM);    // R12

  assert_ack_after_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack) && $past(state_q == S_WAIT)) |-> $past(bus_grant));

  assert_first_cycle_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q == S_WAIT) && in_test) |-> (m_trans == TR_IDLE));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(m_addr) && $stable(m_trans) && $stable(m_write)));

  assert_seq_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_trans == TR_SEQ) |-> $past(m_trans != TR_IDLE));

endmodule

// File: tb/test_tvec_master.sv
module test_tvec_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_a, req_b, bus_grant, m_ready;
  logic [31:0] xd_in, m_rdata;
  logic        ack, xd_oe, bus_req, m_write, m_lock, m_incr_en;
  logic [31:0] xd_out, m_addr, m_wdata;
  logic [1:0]  m_trans;
  logic [2:0]  m_size;
  logic [3:0]  m_prot;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [31:0] RD_WORD = 32'hCAFE_0001;

  always #10 clk = ~clk;

  tvec_master i_tvec_master (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b), .ack(ack),
    .xd_in(xd_in), .xd_out(xd_out), .xd_oe(xd_oe), .bus_req(bus_req),
    .bus_grant(bus_grant), .m_trans(m_trans), .m_addr(m_addr),
    .m_write(m_write), .m_size(m_size), .m_prot(m_prot), .m_lock(m_lock),
    .m_incr_en(m_incr_en), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_ready(m_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One tester cycle: pair announces the next vector, data belongs to the current one
  task automatic vec(input logic [1:0] pair, input logic [31:0] data, input logic rdy = 1'b1);
    @(negedge clk);
    req_a   = pair[1];
    req_b   = pair[0];
    xd_in   = data;
    m_ready = rdy;
    #2;
  endtask

  task automatic t_reset_defaults;
    rst_n = 1'b0; req_a = 0; req_b = 0; bus_grant = 0; m_ready = 1;
    xd_in = '0; m_rdata = RD_WORD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R8 ack", {31'b0, ack}, 0);
    chk("R8 bus_req", {31'b0, bus_req}, 0);
    chk("R8 xd_oe", {31'b0, xd_oe}, 0);
    chk("R8 m_trans", {30'b0, m_trans}, 0);
    chk("R8 m_size", {29'b0, m_size}, 3'b010);
    chk("R8 m_prot", {28'b0, m_prot}, 4'b0011);
    chk("R8 m_lock", {31'b0, m_lock}, 0);
    chk("R8 m_incr_en", {31'b0, m_incr_en}, 0);
  endtask

  task automatic t_enter;
    @(negedge clk); req_a = 1; req_b = 0;
    @(negedge clk); #2;
    chk("R1 bus_req after req_a", {31'b0, bus_req}, 1);
    chk("R1 ack before grant", {31'b0, ack}, 0);
    bus_grant = 1;
    @(negedge clk); #2;
    chk("R1 ack after grant", {31'b0, ack}, 1);
  endtask

  task automatic t_no_addr;
    vec(2'b10, 32'h0);
    vec(2'b10, 32'h1111_1111);
    chk("R10 write before address idle", {30'b0, m_trans}, 0);
    vec(2'b11, 32'h2222_2222);
    chk("R10 still idle", {30'b0, m_trans}, 0);
  endtask

  task automatic t_write;
    vec(2'b10, 32'h0000_1000);
    chk("R3 address vector idle", {30'b0, m_trans}, 0);
    vec(2'b10, 32'hAAAA_0001);
    chk("R3 m_addr latched", m_addr, 32'h0000_1000);
    chk("R4 first write NONSEQ", {30'b0, m_trans}, 2'b10);
    chk("R4 m_write", {31'b0, m_write}, 1);
    chk("R2 no drive on write", {31'b0, xd_oe}, 0);
    vec(2'b11, 32'hAAAA_0002);
    chk("R4 burst SEQ", {30'b0, m_trans}, 2'b11);
    chk("R4 wdata one cycle later", m_wdata, 32'hAAAA_0001);
  endtask

  task automatic t_ctrl;
    vec(2'b11, 32'h0000_2000);
    chk("R4 second wdata", m_wdata, 32'hAAAA_0002);
    vec(2'b10, 32'h0000_02B5);   // valid: size 01, lock, prot 0101, incr
    vec(2'b11, 32'hBBBB_0001);
    chk("R6 control not taken as address", m_addr, 32'h0000_2000);
    chk("R7 size loaded", {29'b0, m_size}, 3'b001);
    chk("R7 prot loaded", {28'b0, m_prot}, 4'b0101);
    chk("R7 lock loaded", {31'b0, m_lock}, 1);
    chk("R7 incr loaded", {31'b0, m_incr_en}, 1);
    chk("R4 NONSEQ after control", {30'b0, m_trans}, 2'b10);
    vec(2'b11, 32'h0000_3000);
    vec(2'b10, 32'h0000_07FC);   // bit 0 low: ignored
    vec(2'b11, 32'hBBBB_0002);
    chk("R6 address after ignored control", m_addr, 32'h0000_3000);
    chk("R7 ignored control size", {29'b0, m_size}, 3'b001);
    chk("R7 ignored control prot", {28'b0, m_prot}, 4'b0101);
    vec(2'b11, 32'h0000_4000);
    vec(2'b01, 32'h0000_0069);   // valid: back to word, prot 0011
  endtask

  task automatic t_read;
    vec(2'b01, 32'h0);
    chk("R5 read address phase", {30'b0, m_trans}, 2'b10);
    chk("R5 m_write low", {31'b0, m_write}, 0);
    chk("R5 first read cycle tristate", {31'b0, xd_oe}, 0);
    chk("R7 size restored", {29'b0, m_size}, 3'b010);
    chk("R7 prot restored", {28'b0, m_prot}, 4'b0011);
    vec(2'b11, 32'h0);
    chk("R5 read burst SEQ", {30'b0, m_trans}, 2'b11);
    chk("R5 drive read data", {31'b0, xd_oe}, 1);
    chk("R5 read data value", xd_out, RD_WORD);
    vec(2'b11, 32'h0);
    chk("R9 turnaround 1 idle", {30'b0, m_trans}, 0);
    chk("R9 last read data driven", {31'b0, xd_oe}, 1);
    vec(2'b10, 32'hDEAD_0000);
    chk("R9 turnaround 2 released", {31'b0, xd_oe}, 0);
    vec(2'b11, 32'hCCCC_0001);
    chk("R9 address kept", m_addr, 32'h0000_4000);
    chk("R9 write after turnaround", {31'b0, m_write}, 1);
  endtask

  task automatic t_stall;
    vec(2'b10, 32'h0000_5000);
    vec(2'b10, 32'hDDDD_0001, 1'b1);
    chk("R11 write address", m_addr, 32'h0000_5000);
    vec(2'b11, 32'hDDDD_0002, 1'b0);
    chk("R11 ack low in stall", {31'b0, ack}, 0);
    chk("R11 SEQ held", {30'b0, m_trans}, 2'b11);
    vec(2'b11, 32'hDDDD_0002, 1'b0);
    chk("R11 still stalled", {31'b0, ack}, 0);
    chk("R11 wdata held", m_wdata, 32'hDDDD_0001);
    vec(2'b11, 32'hDDDD_0002, 1'b1);
    chk("R11 ack back", {31'b0, ack}, 1);
    vec(2'b00, 32'h0000_6000);
    chk("R11 held write taken once", m_wdata, 32'hDDDD_0002);
    chk("R11 idle after burst", {30'b0, m_trans}, 0);
  endtask

  task automatic t_exit;
    vec(2'b00, 32'h0);
    chk("R12 ack during exit vector", {31'b0, ack}, 1);
    chk("R12 bus_req held", {31'b0, bus_req}, 1);
    chk("R3 final address", m_addr, 32'h0000_6000);
    vec(2'b00, 32'h0);
    chk("R12 ack released", {31'b0, ack}, 0);
    chk("R12 bus_req released", {31'b0, bus_req}, 0);
    bus_grant = 0;
  endtask

  initial begin
    t_reset_defaults();
    t_enter();
    t_no_addr();
    t_write();
    t_ctrl();
    t_read();
    t_stall();
    t_exit();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all R) actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule